// File: doc/BRIEF.md
# Keyed-Service Interrupting Watchdog

This block is a watchdog counter clocked by the bus clock and reached through a two-address write port. It has a control register and a service register.

Software enables the watchdog with one write to the control register. The same write picks a power-of-two timeout and sets whether the interrupt is enabled. Software must then keep restarting the count before it runs out. A restart needs two writes to the service register, in order: first the key 0x55, then the key 0xAA.

When the count runs out, the block does not reset anything. It latches a timeout flag, reloads the count and keeps counting. The flag drives an interrupt request through the interrupt-enable bit. The interrupt handler is expected to service the watchdog, or to request a system reset through some other path.

The block has no halt or debug input. The count therefore keeps running while the processor is stopped or stepping.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the block is disabled, `ctrl_o` reads 0x00 and `irq_o` is low.
- R2: A write to address 0 sets the whole control register in one write. Bit 7 is the enable, bits 5:3 are the timeout select, bit 1 is the interrupt enable and bit 0 is the flag. Bits 6 and 2 always read 0. `ctrl_o` shows the new fields on the cycle after the write edge.
- R3: Writing 0x00 to address 0 disables the block. While disabled the count stays at zero and no timeout occurs, however long the wait.
- R4: With select value S, the flag sets exactly 2^(BASE_EXP+S) clock edges after the edge that enabled or restarted the count. With the default BASE_EXP of 21, the code byte 0x30 (S=6) gives 2^27 cycles, about 2.2 s at 60 MHz.
- R5: The flag sets only on a timeout. `irq_o` is high exactly when both the flag and the interrupt-enable bit are 1. The block has no reset output.
- R6: A write of 0x55 to address 1 followed by a write of 0xAA to address 1 restarts the count on the 0xAA write edge. If that edge is also an expiry edge, the restart wins and the flag does not set.
- R7: Any service write other than 0xAA right after 0x55, including a second 0x55, abandons the sequence, and the next restart must begin again with 0x55. A 0xAA write that is not preceded by 0x55 does nothing. Service writes while disabled are ignored.
- R8: The flag clears when a control write has bit 0 set (write-one-to-clear). When a timeout and such a clear fall on the same edge, the flag stays set.
- R9: After a timeout the count reloads and keeps running, so a further timeout follows 2^(BASE_EXP+S) edges later if nothing restarts it.
- R10: A control write that keeps the enable bit at 1 and either changes the select field or turns the enable on reloads the count and drops any half-entered key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 1 | 0 selects the control register, 1 selects the service register |
| wdata_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register readback |
| irq_o | output | 1 | Timeout interrupt request |

## Verification
Two pairs of events can land on the same edge. A timeout can coincide with a write-one-to-clear of the flag, and a timeout can coincide with the 0xAA that completes a restart. The directed part of the bench counts cycles from a known expiry and issues the clear exactly on the next expiry edge; it expects the flag to remain set. The random part uses short periods and heavy service traffic so that both collisions recur many times, and a bench-side cycle model judges each one: set beats clear, and restart beats expiry.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  localparam int BIT_EN   = 7;
  localparam int SEL_HI   = 5;
  localparam int SEL_LO   = 3;
  localparam int BIT_IE   = 1;
  localparam int BIT_FLAG = 0;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SVC  = 1'b1;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic {
    KEY_IDLE,
    KEY_ARMED
  } key_state_e;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_keyed_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [7:0]       data_i,
  input  logic             expire_i,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             ie_o,
  output logic             flag_o,
  output logic             reload_o,
  output logic [7:0]       ctrl_o
);
  logic             ctrl_wr;
  logic             en_q, ie_q, flag_q;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             unused_rsvd;

  assign ctrl_wr     = wr_i && (addr_i == ADDR_CTRL);
  assign sel_d       = data_i[SEL_HI:SEL_LO];
  assign unused_rsvd = ^{data_i[6], data_i[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= data_i[BIT_EN];
        sel_q <= sel_d;
        ie_q  <= data_i[BIT_IE];
      end
      // set has priority over write-one-to-clear
      if (expire_i)
        flag_q <= 1'b1;
      else if (ctrl_wr && data_i[BIT_FLAG])
        flag_q <= 1'b0;
    end
  end

  assign reload_o = ctrl_wr && data_i[BIT_EN] && (!en_q || (sel_d != sel_q));

  assign en_o   = en_q;
  assign sel_o  = sel_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
  assign ctrl_o = {en_q, 1'b0, sel_q, 1'b0, ie_q, flag_q};

  assert_off_on_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL && data_i == 8'h00) |=> !en_o);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_o);

  assert_flag_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(expire_i));
endmodule

// File: rtl/wdt_key_check.sv
module wdt_key_check
  import wdt_keyed_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       svc_wr_i,
  input  logic [7:0] data_i,
  input  logic       clear_i,
  output logic       kick_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i || clear_i)
      state_d = KEY_IDLE;
    else if (svc_wr_i) begin
      if (state_q == KEY_IDLE && data_i == KEY_ARM)
        state_d = KEY_ARMED;
      else
        state_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

  assign kick_o = en_i && !clear_i && svc_wr_i && (state_q == KEY_ARMED) && (data_i == KEY_FIRE);

  assert_kick_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> (state_q == KEY_IDLE));

  assert_arm_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == KEY_ARMED) |-> $past(svc_wr_i && data_i == KEY_ARM));
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_keyed_pkg::*;
#(
  parameter int BASE_EXP = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             reload_i,
  input  logic             kick_i,
  output logic             expire_o
);
  localparam int CNT_W = BASE_EXP + NUM_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_tab [NUM_SEL];
  logic [CNT_W-1:0] limit;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
  end

  assign limit    = lim_tab[sel_i];
  assign expire_o = en_i && !reload_i && !kick_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (!en_i || reload_i || kick_i || expire_o)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_idle_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  assert_wrap_after_expiry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int BASE_EXP = 21
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl_o,
  output logic       irq_o
);
  logic             en, ie, flag, reload, kick, expire, svc_wr;
  logic [SEL_W-1:0] sel;

  assign svc_wr = wr_i && (addr_i == ADDR_SVC);

  wdt_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .data_i   (wdata_i),
    .expire_i (expire),
    .en_o     (en),
    .sel_o    (sel),
    .ie_o     (ie),
    .flag_o   (flag),
    .reload_o (reload),
    .ctrl_o   (ctrl_o)
  );

  wdt_key_check u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .svc_wr_i (svc_wr),
    .data_i   (wdata_i),
    .clear_i  (reload),
    .kick_o   (kick)
  );

  wdt_count #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .sel_i    (sel),
    .reload_i (reload),
    .kick_i   (kick),
    .expire_o (expire)
  );

  assign irq_o = flag && ie;

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_o[BIT_FLAG] && ctrl_o[BIT_IE]));
endmodule

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam int BASE = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] ctrl_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  wdt_keyed #(.BASE_EXP(BASE)) u_wdt_keyed (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ctrl_o(ctrl_o), .irq_o(irq_o)
  );

  // reference cycle model built from the requirements
  bit m_en, m_ie, m_flag, m_armed;
  int m_sel, m_cnt;

  function automatic int period_of(int s);
    return 1 << (BASE + s);
  endfunction

  function automatic logic [7:0] model_ctrl();
    return {m_en, 1'b0, 3'(m_sel), 1'b0, m_ie, m_flag};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_ie = 0; m_flag = 0; m_armed = 0; m_sel = 0; m_cnt = 0;
    end else begin
      bit cw, sw, rl, kk, ex;
      int nsel;
      cw = wr_i && !addr_i;
      sw = wr_i && addr_i;
      nsel = int'(wdata_i[5:3]);
      rl = cw && wdata_i[7] && (!m_en || nsel != m_sel);
      kk = m_en && sw && m_armed && wdata_i == 8'hAA;
      ex = m_en && !rl && !kk && (m_cnt == period_of(m_sel) - 1);
      if (!m_en || rl || kk || ex) m_cnt = 0; else m_cnt++;
      if (!m_en || rl) m_armed = 0;
      else if (sw) m_armed = !m_armed && wdata_i == 8'h55;
      if (ex) m_flag = 1; else if (cw && wdata_i[0]) m_flag = 0;
      if (cw) begin m_en = wdata_i[7]; m_sel = nsel; m_ie = wdata_i[1]; end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (ctrl_o !== model_ctrl() || irq_o !== (m_flag && m_ie)) begin
        errors++;
        $display("FAIL R4/R6 model: ctrl=%02h irq=%b expected ctrl=%02h irq=%b",
                 ctrl_o, irq_o, model_ctrl(), m_flag && m_ie);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_now(bit a, logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    while (!ctrl_o[0] && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 ctrl", ctrl_o, 0);
    check("R1 irq", irq_o, 0);

    wr_now(0, 8'h82);
    check("R2 readback", ctrl_o, 8'h82);
    wait_flag(n);
    check("R4 period sel0", n, period_of(0));
    check("R5 irq on flag", irq_o, 1);

    wr_now(0, 8'h83);
    check("R8 w1c", ctrl_o[0], 0);
    wait_flag(n);
    check("R9 second timeout", n, period_of(0) - 1);

    repeat (3) @(negedge clk_i);
    wr_now(0, 8'h83);
    check("R8 set wins", ctrl_o[0], 1);

    wr_now(0, 8'h00);
    check("R3 zero disables", ctrl_o, 8'h01);
    wr_now(0, 8'h01);
    repeat (600) @(negedge clk_i);
    check("R3 no timeout when off", ctrl_o, 0);
    check("R3 irq low", irq_o, 0);

    wr_now(0, 8'h8A);
    for (int i = 0; i < 10; i++) begin
      repeat (3) @(negedge clk_i);
      wr_now(1, 8'h55);
      wr_now(1, 8'hAA);
    end
    check("R6 serviced no flag", ctrl_o[0], 0);

    wr_now(1, 8'hAA);
    wait_flag(n);
    check("R7 lone AA ignored", n, period_of(1) - 1);

    wr_now(0, 8'h8B);
    wr_now(1, 8'h55);
    wr_now(1, 8'hAA);
    wr_now(1, 8'h55);
    wr_now(1, 8'h12);
    wr_now(1, 8'hAA);
    wait_flag(n);
    check("R7 wrong key abandons", n, period_of(1) - 3);

    wr_now(0, 8'h8B);
    wr_now(1, 8'h55);
    wr_now(1, 8'hAA);
    wr_now(1, 8'h55);
    wr_now(1, 8'h55);
    wr_now(1, 8'hAA);
    wait_flag(n);
    check("R7 double 55 abandons", n, period_of(1) - 3);

    wr_now(1, 8'h55);
    wr_now(1, 8'hAA);
    wr_now(1, 8'h55);
    wr_now(0, 8'h93);
    check("R10 new select readback", ctrl_o, 8'h92);
    wr_now(1, 8'hAA);
    wait_flag(n);
    check("R10 reload and key drop", n, period_of(2) - 1);

    // random phase, judged by the cycle model
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 35) begin
        if ($urandom_range(99) < 75) begin
          int r;
          logic [7:0] d;
          r = $urandom_range(99);
          d = (r < 45) ? 8'h55 : (r < 90) ? 8'hAA : 8'($urandom);
          wr_now(1, d);
        end else begin
          logic [7:0] d;
          d = 8'($urandom);
          d[5:3] = 3'($urandom_range(3));
          d[7] = ($urandom_range(99) < 85);
          wr_now(0, d);
        end
      end else begin
        @(negedge clk_i);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule